// File: doc/BRIEF.md
# Trace Configuration Register File

This block holds the configuration state of an instruction-trace unit: a control word with an enable bit and two output-routing bits, a status word with a sticky error flag, and a base address for trace output. Software reaches the three registers through a simple request/response port. Each request is taken in one cycle and answered exactly one cycle later. The answer carries read data or a fault flag.

The block guards the configuration. While tracing runs, the only write it accepts is one that also turns tracing off. With the feature absent, every access faults. Routing to the transport fabric needs a capability strap. It drives the enable and the routing choice to the packet logic, and it takes an error line from the output path that stops tracing and latches the error.

Top module: `trace_cfg_regs`

## Requirements
- R1: After reset every register reads zero, `traceEn` is 0, `outSel` is 0 and `outBase` is 0.
- R2: A request sampled with `regValid` high gives `rspValid` high for exactly the next cycle. With no request, `rspValid` stays low.
- R3: While `featureSupported` is 0, every read and write faults and changes no register or output.
- R4: A write faults and is not applied when the enable bit is 1 before it and would still be 1 after it. For the control register, "after" is bit 0 of the write data. For every other address it is the unchanged current enable.
- R5: A control write with bit 0 clear is accepted while tracing runs, and all three control bits take the written values.
- R6: A control write with bit 2 set faults and is not applied while `fabricCapable` is 0.
- R7: `outSel` is 2 when the fabric bit is set, whatever the table bit is. It is 1 when only the table bit is set, and 0 otherwise.
- R8: A high `outErr` sets the status error bit and clears the enable bit on the next edge. This takes priority over a write in the same cycle.
- R9: The status error bit takes bit 0 of an accepted status write, so writing 0 clears it. Because of R4, such a write is accepted only while tracing is disabled.
- R10: A faulting request returns `rspFault` high for one cycle with `rspRdata` zero. Accepted writes also return zero data.
- R11: Register map. Address 0 is control: bit 0 enable, bit 1 table mode, bit 2 fabric mode. Address 1 is status: bit 0 error. Address 2 is the output base, whose low `BASE_ALIGN` bits always read zero. Any other address faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Request strobe |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | ADDR_W | Register address |
| regWdata | input | DATA_W | Write data |
| featureSupported | input | 1 | Trace feature present |
| fabricCapable | input | 1 | Fabric routing allowed |
| outErr | input | 1 | Error report from output path |
| rspValid | output | 1 | Response strobe, one cycle after request |
| rspFault | output | 1 | Request faulted |
| rspRdata | output | DATA_W | Read data, zero on fault or write |
| traceEn | output | 1 | Tracing enabled |
| outSel | output | 2 | Output route: 0 direct, 1 table, 2 fabric |
| outBase | output | DATA_W | Output base address |

## Verification
The bench builds the block with `DATA_W` = 16, `ADDR_W` = 2 and `BASE_ALIGN` = 4. Two address bits bring the unmapped fourth address within reach. The narrow data path lets an all-ones pattern show the alignment mask on the base register. The sweep covers all eight prior control states, every address, every control value and both capability and feature settings. This reaches each combination of prior enable, next enable and fabric request. Further cases put an output-path error in the same cycle as a write that sets the enable.

// File: rtl/trc_cfg_pkg.sv
package trc_cfg_pkg;

  typedef enum logic [1:0] {
    OUT_DIRECT = 2'd0,
    OUT_TABLE  = 2'd1,
    OUT_FABRIC = 2'd2
  } outSel_e;

  localparam int BIT_EN  = 0;
  localparam int BIT_TAB = 1;
  localparam int BIT_FAB = 2;
  localparam int BIT_ERR = 0;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_STAT = 1;
  localparam int ADDR_BASE = 2;

  typedef struct packed {
    logic wrCtrl;
    logic wrStat;
    logic wrBase;
    logic rdCtrl;
    logic rdStat;
    logic rdBase;
    logic fault;
    logic fire;
  } strobe_t;

endpackage

// File: rtl/trc_cfg_ctl.sv
module trc_cfg_ctl
  import trc_cfg_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              featureSupported,
  input  logic              fabricCapable,
  input  logic              curEn,
  output strobe_t           strobes
);

  logic isCtrl, isStat, isBase, mapped;
  logic enAfter, lockViol, fabViol, faultNow, accept;

  always_comb begin
    isCtrl = (regAddr == ADDR_W'(ADDR_CTRL));
    isStat = (regAddr == ADDR_W'(ADDR_STAT));
    isBase = (regAddr == ADDR_W'(ADDR_BASE));
    mapped = isCtrl | isStat | isBase;
  end

  // Enable state the write would leave behind.
  always_comb begin
    enAfter  = isCtrl ? regWdata[BIT_EN] : curEn;
    lockViol = regWrite & curEn & enAfter;
    fabViol  = regWrite & isCtrl & regWdata[BIT_FAB] & ~fabricCapable;
  end

  always_comb begin
    faultNow = regValid & (~featureSupported | ~mapped | lockViol | fabViol);
    accept   = regValid & ~faultNow;
  end

  always_comb begin
    strobes        = '0;
    strobes.fire   = regValid;
    strobes.fault  = faultNow;
    strobes.wrCtrl = accept &  regWrite & isCtrl;
    strobes.wrStat = accept &  regWrite & isStat;
    strobes.wrBase = accept &  regWrite & isBase;
    strobes.rdCtrl = accept & ~regWrite & isCtrl;
    strobes.rdStat = accept & ~regWrite & isStat;
    strobes.rdBase = accept & ~regWrite & isBase;
  end

endmodule

// File: rtl/trc_cfg_dp.sv
module trc_cfg_dp
  import trc_cfg_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int BASE_ALIGN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              outErr,
  output logic              rspValid,
  output logic              rspFault,
  output logic [DATA_W-1:0] rspRdata,
  output logic              traceEn,
  output logic [1:0]        outSel,
  output logic [DATA_W-1:0] outBase
);

  localparam int CTRL_BITS = 3;

  logic              ctrlEn, ctrlTab, ctrlFab, statErr;
  logic [DATA_W-1:0] baseQ, baseMask, rdMux;

  // Alignment mask for the base register; low bits never stored.
  for (genvar b = 0; b < DATA_W; b++) begin : g_mask
    if (b < BASE_ALIGN) begin : g_lo
      assign baseMask[b] = 1'b0;
    end else begin : g_hi
      assign baseMask[b] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlEn  <= 1'b0;
      ctrlTab <= 1'b0;
      ctrlFab <= 1'b0;
      statErr <= 1'b0;
      baseQ   <= '0;
    end else begin
      if (strobes.wrCtrl) begin
        ctrlEn  <= regWdata[BIT_EN];
        ctrlTab <= regWdata[BIT_TAB];
        ctrlFab <= regWdata[BIT_FAB];
      end
      if (strobes.wrStat) statErr <= regWdata[BIT_ERR];
      if (strobes.wrBase) baseQ   <= regWdata & baseMask;
      // Output-path error wins over any same-cycle write.
      if (outErr) begin
        statErr <= 1'b1;
        ctrlEn  <= 1'b0;
      end
    end
  end

  always_comb begin
    rdMux = '0;
    if (strobes.rdCtrl) rdMux[CTRL_BITS-1:0] = {ctrlFab, ctrlTab, ctrlEn};
    if (strobes.rdStat) rdMux[BIT_ERR]       = statErr;
    if (strobes.rdBase) rdMux                = baseQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspFault <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= strobes.fire;
      rspFault <= strobes.fault;
      rspRdata <= rdMux;
    end
  end

  always_comb begin
    if (ctrlFab)      outSel = OUT_FABRIC;
    else if (ctrlTab) outSel = OUT_TABLE;
    else              outSel = OUT_DIRECT;
  end

  assign traceEn = ctrlEn;
  assign outBase = baseQ;

endmodule

// File: rtl/trace_cfg_regs.sv
module trace_cfg_regs
  import trc_cfg_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 32,
  parameter int BASE_ALIGN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              featureSupported,
  input  logic              fabricCapable,
  input  logic              outErr,
  output logic              rspValid,
  output logic              rspFault,
  output logic [DATA_W-1:0] rspRdata,
  output logic              traceEn,
  output logic [1:0]        outSel,
  output logic [DATA_W-1:0] outBase
);

  strobe_t strobes;

  trc_cfg_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctl_i (
    .regValid         (regValid),
    .regWrite         (regWrite),
    .regAddr          (regAddr),
    .regWdata         (regWdata),
    .featureSupported (featureSupported),
    .fabricCapable    (fabricCapable),
    .curEn            (traceEn),
    .strobes          (strobes)
  );

  trc_cfg_dp #(.DATA_W(DATA_W), .BASE_ALIGN(BASE_ALIGN)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .regWdata (regWdata),
    .outErr   (outErr),
    .rspValid (rspValid),
    .rspFault (rspFault),
    .rspRdata (rspRdata),
    .traceEn  (traceEn),
    .outSel   (outSel),
    .outBase  (outBase)
  );

endmodule

// File: rtl/trace_cfg_regs_chk.sv
module trace_cfg_regs_chk #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regValid,
  input logic              regWrite,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic              featureSupported,
  input logic              fabricCapable,
  input logic              outErr,
  input logic              rspValid,
  input logic              rspFault,
  input logic [DATA_W-1:0] rspRdata,
  input logic              traceEn,
  input logic [1:0]        outSel,
  input logic [DATA_W-1:0] outBase
);

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    regValid |=> rspValid);

  assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !regValid |=> !rspValid);

  assert_unsupported_faults_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && !featureSupported) |=> rspFault);

  assert_unsupported_inert_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && !featureSupported && !outErr) |=>
      ($stable(traceEn) && $stable(outSel) && $stable(outBase)));

  assert_locked_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && regWrite && traceEn && !(regAddr == '0 && !regWdata[0])) |=> rspFault);

  assert_fabric_cap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && regWrite && regAddr == '0 && regWdata[2] && !fabricCapable) |=> rspFault);

  assert_err_stops_R8: assert property (@(posedge clk) disable iff (!rstN)
    outErr |=> !traceEn);

  assert_fault_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> (rspValid && rspRdata == '0));

  assert_sel_legal_R7: assert property (@(posedge clk) disable iff (!rstN)
    outSel != 2'd3);

endmodule

bind trace_cfg_regs trace_cfg_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
  .regAddr(regAddr), .regWdata(regWdata), .featureSupported(featureSupported),
  .fabricCapable(fabricCapable), .outErr(outErr), .rspValid(rspValid),
  .rspFault(rspFault), .rspRdata(rspRdata), .traceEn(traceEn),
  .outSel(outSel), .outBase(outBase)
);

// File: tb/trace_cfg_regs_tb_top.sv
module trace_cfg_regs_tb_top;

  localparam int DW = 16;
  localparam int AW = 2;
  localparam int AL = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic          regValid = 1'b0, regWrite = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [DW-1:0] regWdata = '0;
  logic          featureSupported = 1'b1, fabricCapable = 1'b1, outErr = 1'b0;
  logic          rspValid, rspFault, traceEn;
  logic [DW-1:0] rspRdata, outBase;
  logic [1:0]    outSel;

  trace_cfg_regs #(.ADDR_W(AW), .DATA_W(DW), .BASE_ALIGN(AL)) dut_i (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .featureSupported(featureSupported),
    .fabricCapable(fabricCapable), .outErr(outErr), .rspValid(rspValid),
    .rspFault(rspFault), .rspRdata(rspRdata), .traceEn(traceEn),
    .outSel(outSel), .outBase(outBase)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic          mEn = 0, mTab = 0, mFab = 0, mErr = 0;
  logic [DW-1:0] mBase = '0;

  task automatic chk(input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkOutputs(input string req);
    logic [1:0] expSel;
    expSel = mFab ? 2'd2 : (mTab ? 2'd1 : 2'd0);
    chk(req, "traceEn", DW'(traceEn), DW'(mEn));
    chk(req, "outSel",  DW'(outSel),  DW'(expSel));
    chk(req, "outBase", outBase, mBase);
  endtask

  task automatic access(input string req, input bit wr, input int addr,
                        input logic [DW-1:0] wd, input bit sup, input bit cap,
                        input bit err);
    bit            expFault;
    logic [DW-1:0] expRd;
    expFault = !sup || addr == 3 ||
               (wr && mEn && !(addr == 0 && wd[0] == 1'b0)) ||
               (wr && addr == 0 && wd[2] && !cap);
    expRd = '0;
    if (!expFault && !wr) begin
      if (addr == 0) expRd = DW'({mFab, mTab, mEn});
      if (addr == 1) expRd = DW'(mErr);
      if (addr == 2) expRd = mBase;
    end
    if (!expFault && wr) begin
      if (addr == 0) begin mEn = wd[0]; mTab = wd[1]; mFab = wd[2]; end
      if (addr == 1) mErr = wd[0];
      if (addr == 2) mBase = wd & ~DW'((1 << AL) - 1);
    end
    if (err) begin mErr = 1'b1; mEn = 1'b0; end
    @(negedge clk);
    regValid = 1'b1; regWrite = wr; regAddr = AW'(addr); regWdata = wd;
    featureSupported = sup; fabricCapable = cap; outErr = err;
    @(negedge clk);
    regValid = 1'b0; outErr = 1'b0;
    chk(req, "rspValid", DW'(rspValid), DW'(1));
    chk(req, "rspFault", DW'(rspFault), DW'(expFault));
    chk(req, "rspRdata", rspRdata, expRd);
    checkOutputs(req);
  endtask

  task automatic readAll(input string req);
    access(req, 1'b0, 0, '0, 1'b1, 1'b1, 1'b0);
    access(req, 1'b0, 1, '0, 1'b1, 1'b1, 1'b0);
    access(req, 1'b0, 2, '0, 1'b1, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset values on outputs and in every register
    checkOutputs("R1");
    chk("R2", "rspValid idle", DW'(rspValid), DW'(0));
    readAll("R1");

    // R2: response is a single-cycle pulse
    @(negedge clk);
    chk("R2", "rspValid drop", DW'(rspValid), DW'(0));

    // Sweep: feature x capability x prior control x address x data x direction
    for (int sup = 0; sup < 2; sup++)
      for (int cap = 0; cap < 2; cap++)
        for (int pre = 0; pre < 8; pre++)
          for (int addr = 0; addr < 4; addr++)
            for (int vi = 0; vi < 11; vi++)
              for (int wr = 0; wr < 2; wr++) begin
                logic [DW-1:0] v;
                string tag;
                v = (vi < 8) ? DW'(vi) : (vi == 8 ? 16'hA5F3 : (vi == 9 ? 16'hFFFF : 16'h5A0E));
                access("R5", 1'b1, 0, '0, 1'b1, 1'b1, 1'b0);
                access("R9", 1'b1, 1, DW'(pre & 1), 1'b1, 1'b1, 1'b0);
                access("R7", 1'b1, 0, DW'(pre), 1'b1, 1'b1, 1'b0);
                if (sup == 0)                                   tag = "R3";
                else if (addr == 3)                             tag = "R11";
                else if (wr == 1 && addr == 0 && v[2] && cap == 0) tag = "R6";
                else if (wr == 1 && mEn && addr == 0 && !v[0])  tag = "R5";
                else if (wr == 1 && mEn)                        tag = "R4";
                else if (addr == 1)                             tag = "R9";
                else if (wr == 0)                               tag = "R10";
                else                                            tag = "R7";
                access(tag, wr[0], addr, v, sup[0], cap[0], 1'b0);
                readAll("R11");
              end

    // R8: output error while running stops tracing and latches the flag
    access("R8", 1'b1, 0, '0, 1'b1, 1'b1, 1'b0);
    access("R8", 1'b1, 0, 16'h0003, 1'b1, 1'b1, 1'b0);
    access("R8", 1'b0, 0, '0, 1'b1, 1'b1, 1'b1);
    readAll("R8");
    // R8: error beats a same-cycle enabling write and a same-cycle clear
    access("R8", 1'b1, 1, '0, 1'b1, 1'b1, 1'b0);
    access("R8", 1'b1, 0, 16'h0005, 1'b1, 1'b1, 1'b1);
    access("R8", 1'b1, 1, '0, 1'b1, 1'b1, 1'b1);
    readAll("R8");
    // R9: clear error after stop, then a status write while running faults
    access("R9", 1'b1, 1, '0, 1'b1, 1'b1, 1'b0);
    access("R9", 1'b1, 0, 16'h0001, 1'b1, 1'b1, 1'b0);
    access("R9", 1'b1, 1, 16'h0001, 1'b1, 1'b1, 1'b0);
    readAll("R9");
    // R3: error input still acts while the feature is absent
    access("R3", 1'b0, 0, '0, 1'b0, 1'b1, 1'b1);
    readAll("R3");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule